// File: doc/BRIEF.md
# Scalar-to-Vector Factor and Mask Generator

This block forms the side outputs that a scalar instruction hands to the vector unit. There are four signed fixed-point factors, each 10 bits wide with 8 fractional bits, and two 16-bit lane masks. A 2-bit mode selects how the factors are made.

- **Immediate mode:** two 9-bit signed immediates each feed one pair of factors.
- **Shift mode:** the four low bits of the scalar source feed the first pair, and the second pair is cleared.

The masks are never computed on their own. Both masks are always taken from bits 1 to 8 of the factor pairs through one fixed wiring path. As a result, every mode produces a mask that is tied to its factors.

A small two-state controller registers the results. In `ST_IDLE` no new result is present. In `ST_EMIT` a result captured on the previous edge is being presented. The controller has four transitions:

- **accept** (`ST_IDLE` to `ST_EMIT`): taken when `in_valid` is high.
- **stream** (`ST_EMIT` to `ST_EMIT`): taken on back-to-back inputs.
- **drain** (`ST_EMIT` to `ST_IDLE`): taken when no input follows.
- **wait** (`ST_IDLE` to `ST_IDLE`): taken while no input is present.

The factor register loads only on an accepted input. At all other times it holds its value.

Top module: `s2v_factor_gen`

## Requirements
- R1: After reset `out_valid` is 0, `fac_o` is all zero, and both masks are zero.
- R2: With mode code 1 (immediate), factors 0 and 1 equal `imm_a` shifted left by one bit into 10 bits. Factors 2 and 3 equal `imm_b` treated the same way. Bit 9 therefore carries the immediate's sign. Factor k occupies `fac_o[10k+9:10k]`.
- R3: In every mode, `mask0_o` equals {factor1[8:1], factor0[8:1]} and `mask1_o` equals {factor3[8:1], factor2[8:1]}. For immediate mode this gives each mask as the low 8 bits of its immediate, repeated twice.
- R4: With mode code 2 (shift), nibble i of `mask0_o` is four copies of `src[i]` for i = 0..3. For example, source 0xa gives 0xf0f0.
- R5: In shift mode, factor 0 is `mask0_o[7:0]` shifted left by one bit and factor 1 is `mask0_o[15:8]` shifted left by one bit. Both factors are non-negative (bit 9 clear).
- R6: In shift mode, factors 2 and 3 and `mask1_o` are zero. `src` bits 4 and above have no effect on any output.
- R7: Mode codes 0 and 3 yield all-zero factors and masks.
- R8: `out_valid` is high for exactly the cycle after each cycle with `in_valid` high. While `in_valid` is low, factors and masks hold, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the current mode and operands |
| mode | input | 2 | 0 zero, 1 immediate, 2 shift, 3 zero |
| imm_a | input | 9 | Signed immediate for factors 0 and 1 |
| imm_b | input | 9 | Signed immediate for factors 2 and 3 |
| src | input | 32 | Scalar source; low 4 bits used in shift mode |
| out_valid | output | 1 | New result present this cycle |
| fac_o | output | 40 | Four 10-bit factors, factor k at bits 10k+9:10k |
| mask0_o | output | 16 | Lane mask from factors 0 and 1 |
| mask1_o | output | 16 | Lane mask from factors 2 and 3 |

## Verification
Immediate mode is driven with several kinds of immediates:

- Mixed positive immediates with distinct values per pair, which tell `imm_a` apart from `imm_b` and separate the pairs.
- The extremes -1 and -256, which expose sign handling in bit 9 and the drop of the immediate's top bit from the mask.
- The largest positive value, 255.

Shift mode is driven with alternating, all-ones and all-zero nibbles, which separate the nibble replication order. A source whose upper bits are all set, with a zero low nibble, shows that only the shifted-out bits matter. Both unused mode codes are also driven.

Back-to-back inputs exercise the stream transition. Idle gaps are filled with changing operands to show that the outputs hold while no input is accepted.

// File: rtl/s2v_pkg.sv
package s2v_pkg;

    // Operation select driving the factor source
    typedef enum logic [1:0] {
        MODE_ZERO  = 2'd0,
        MODE_IMM   = 2'd1,
        MODE_SHIFT = 2'd2,
        MODE_RSVD  = 2'd3
    } s2v_mode_e;

    // Output controller states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } s2v_state_e;

endpackage

// File: rtl/s2v_imm_path.sv
module s2v_imm_path #(
    parameter int IMM_W = 9,
    parameter int FAC_W = 10,
    parameter int N_FAC = 4
) (
    input  logic [IMM_W-1:0]       imm_a,
    input  logic [IMM_W-1:0]       imm_b,
    output logic [N_FAC*FAC_W-1:0] fac
);
    localparam int HALF = N_FAC / 2;

    // Each immediate is sign-extended and moved up one bit so that
    // its low byte lands on the bits the mask wiring taps.
    for (genvar k = 0; k < N_FAC; k++) begin : g_fac
        logic [IMM_W-1:0] pick;
        if (k < HALF) begin : g_lo
            assign pick = imm_a;
        end else begin : g_hi
            assign pick = imm_b;
        end
        assign fac[k*FAC_W +: FAC_W] = FAC_W'($signed(pick)) << 1;
    end

endmodule

// File: rtl/s2v_shift_path.sv
module s2v_shift_path #(
    parameter int SHIFT  = 4,
    parameter int FRAC_W = 8,
    parameter int FAC_W  = 10,
    parameter int N_FAC  = 4
) (
    input  logic [SHIFT-1:0]       lost_bits,
    output logic [N_FAC*FAC_W-1:0] fac
);
    localparam int MASK_W = 2 * FRAC_W;
    localparam int REP    = MASK_W / SHIFT;

    logic [MASK_W-1:0] spread;

    // Every bit pushed out by the shift covers one group of lanes.
    for (genvar i = 0; i < SHIFT; i++) begin : g_spread
        assign spread[i*REP +: REP] = {REP{lost_bits[i]}};
    end

    // First pair carries the spread bytes one bit up; second pair is idle.
    for (genvar k = 0; k < N_FAC; k++) begin : g_fac
        if (k < 2) begin : g_used
            assign fac[k*FAC_W +: FAC_W] =
                FAC_W'({spread[k*FRAC_W +: FRAC_W], 1'b0});
        end else begin : g_zero
            assign fac[k*FAC_W +: FAC_W] = '0;
        end
    end

endmodule

// File: rtl/s2v_mask_tap.sv
module s2v_mask_tap #(
    parameter int FRAC_W = 8,
    parameter int FAC_W  = 10,
    parameter int N_FAC  = 4
) (
    input  logic [N_FAC*FAC_W-1:0]            fac,
    output logic [(N_FAC/2)*2*FRAC_W-1:0]     masks
);
    localparam int MASK_W = 2 * FRAC_W;
    localparam int N_MASK = N_FAC / 2;

    logic [N_FAC-1:0] edge_unused;

    // A mask is nothing but the middle bits of its factor pair.
    for (genvar m = 0; m < N_MASK; m++) begin : g_mask
        assign masks[m*MASK_W +: FRAC_W] =
            fac[(2*m)*FAC_W + 1 +: FRAC_W];
        assign masks[m*MASK_W + FRAC_W +: FRAC_W] =
            fac[(2*m+1)*FAC_W + 1 +: FRAC_W];
    end

    for (genvar k = 0; k < N_FAC; k++) begin : g_edge
        assign edge_unused[k] = fac[k*FAC_W] ^ fac[k*FAC_W + FAC_W - 1];
    end

endmodule

// File: rtl/s2v_factor_gen.sv
module s2v_factor_gen
    import s2v_pkg::*;
#(
    parameter int SRC_W  = 32,
    parameter int IMM_W  = 9,
    parameter int FRAC_W = 8,
    parameter int SHIFT  = 4,
    parameter int N_FAC  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [1:0]            mode,
    input  logic [IMM_W-1:0]      imm_a,
    input  logic [IMM_W-1:0]      imm_b,
    input  logic [SRC_W-1:0]      src,
    output logic                  out_valid,
    output logic [N_FAC*10-1:0]   fac_o,
    output logic [2*FRAC_W-1:0]   mask0_o,
    output logic [2*FRAC_W-1:0]   mask1_o
);
    localparam int FAC_W  = FRAC_W + 2;
    localparam int MASK_W = 2 * FRAC_W;
    localparam int N_MASK = N_FAC / 2;
    localparam int BUS_W  = N_FAC * FAC_W;

    s2v_state_e        state_q, state_d;
    s2v_mode_e         mode_sel;
    logic [BUS_W-1:0]  imm_fac, shift_fac, next_fac, fac_q;
    logic [N_MASK*MASK_W-1:0] mask_bus;
    logic              src_unused;

    assign mode_sel   = s2v_mode_e'(mode);
    assign src_unused = ^src[SRC_W-1:SHIFT];

    s2v_imm_path #(
        .IMM_W (IMM_W),
        .FAC_W (FAC_W),
        .N_FAC (N_FAC)
    ) u_imm (
        .imm_a (imm_a),
        .imm_b (imm_b),
        .fac   (imm_fac)
    );

    s2v_shift_path #(
        .SHIFT  (SHIFT),
        .FRAC_W (FRAC_W),
        .FAC_W  (FAC_W),
        .N_FAC  (N_FAC)
    ) u_shift (
        .lost_bits (src[SHIFT-1:0]),
        .fac       (shift_fac)
    );

    // Source select for the factor register
    always_comb begin
        unique case (mode_sel)
            MODE_IMM:   next_fac = imm_fac;
            MODE_SHIFT: next_fac = shift_fac;
            default:    next_fac = '0;
        endcase
    end

    // Next-state logic: accept / stream / drain / wait
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register: loads only on an accepted input
    always_ff @(posedge clk) begin
        if (!rst_n)        fac_q <= '0;
        else if (in_valid) fac_q <= next_fac;
    end

    s2v_mask_tap #(
        .FRAC_W (FRAC_W),
        .FAC_W  (FAC_W),
        .N_FAC  (N_FAC)
    ) u_tap (
        .fac   (fac_q),
        .masks (mask_bus)
    );

    assign out_valid = (state_q == ST_EMIT);
    assign fac_o     = fac_q;
    assign mask0_o   = mask_bus[0 +: MASK_W];
    assign mask1_o   = mask_bus[MASK_W +: MASK_W];

endmodule

// File: rtl/s2v_factor_gen_chk.sv
module s2v_factor_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  mode,
    input logic [8:0]  imm_a,
    input logic [8:0]  imm_b,
    input logic        out_valid,
    input logic [39:0] fac_o,
    input logic [15:0] mask0_o,
    input logic [15:0] mask1_o
);
    // R8
    out_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    out_valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(fac_o) && $stable(mask0_o) && $stable(mask1_o)));

    // R2
    imm_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd1) |=>
            (fac_o[9:0] == {$past(imm_a), 1'b0}) &&
            (fac_o[29:20] == {$past(imm_b), 1'b0}));

    // R6
    shift_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd2) |=> (fac_o[39:20] == '0) && (mask1_o == '0));

    // R7
    unused_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == 2'd0 || mode == 2'd3)) |=>
            (fac_o == '0) && (mask0_o == '0) && (mask1_o == '0));

endmodule

bind s2v_factor_gen s2v_factor_gen_chk u_chk (.*);

// File: tb/s2v_factor_gen_test.sv
module s2v_factor_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [8:0]  imm_a = '0;
    logic [8:0]  imm_b = '0;
    logic [31:0] src = '0;
    logic        out_valid;
    logic [39:0] fac_o;
    logic [15:0] mask0_o;
    logic [15:0] mask1_o;

    int checks = 0;
    int fails  = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [39:0] fac;
        logic [15:0] m0;
        logic [15:0] m1;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t last;
    exp_t cur;

    always #5 clk = ~clk;

    s2v_factor_gen uut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .mode (mode),
        .imm_a (imm_a), .imm_b (imm_b), .src (src), .out_valid (out_valid),
        .fac_o (fac_o), .mask0_o (mask0_o), .mask1_o (mask1_o)
    );

    task automatic chk(input logic [39:0] act, input logic [39:0] exp,
                       input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Model written from the requirements
    function automatic exp_t model(input logic [1:0] md, input logic [8:0] a,
                                   input logic [8:0] b, input logic [31:0] s,
                                   input string tag);
        exp_t e;
        logic [15:0] m;
        e.tag = tag;
        e.fac = '0; e.m0 = '0; e.m1 = '0;
        if (md == 2'd1) begin
            e.fac = {b, 1'b0, b, 1'b0, a, 1'b0, a, 1'b0};
            e.m0  = {a[7:0], a[7:0]};
            e.m1  = {b[7:0], b[7:0]};
        end else if (md == 2'd2) begin
            for (int i = 0; i < 4; i++) m[i*4 +: 4] = {4{s[i]}};
            e.m0  = m;
            e.fac = {20'd0, 1'b0, m[15:8], 1'b0, 1'b0, m[7:0], 1'b0};
        end
        return e;
    endfunction

    task automatic send(input logic [1:0] md, input logic [8:0] a,
                        input logic [8:0] b, input logic [31:0] s,
                        input string tag);
        @(negedge clk);
        in_valid = 1'b1; mode = md; imm_a = a; imm_b = b; src = s;
        q.push_back(model(md, a, b, s, tag));
    endtask

    // Idle cycles with junk on the operands (R8: must be ignored)
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            mode  = 2'(k + 1);
            imm_a = 9'h1a5 + 9'(k * 37);
            imm_b = 9'h05a ^ 9'(k * 91);
            src   = 32'hdead_beef + 32'(k);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (started && rst_n) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk(40'd1, 40'd0, "R8", "out_valid with nothing pending");
                end else begin
                    cur = q.pop_front();
                    chk(fac_o, cur.fac, cur.tag, "factors");
                    chk({24'd0, mask0_o}, {24'd0, cur.m0}, cur.tag, "mask0");
                    chk({24'd0, mask1_o}, {24'd0, cur.m1}, cur.tag, "mask1");
                    chk({24'd0, mask0_o}, {24'd0, fac_o[18:11], fac_o[8:1]},
                        "R3", "mask0 tie");
                    chk({24'd0, mask1_o}, {24'd0, fac_o[38:31], fac_o[28:21]},
                        "R3", "mask1 tie");
                    last = cur;
                end
            end else begin
                chk(fac_o, last.fac, "R8", "hold factors");
                chk({24'd0, mask0_o, mask1_o}, {24'd0, last.m0, last.m1},
                    "R8", "hold masks");
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        last.fac = '0; last.m0 = '0; last.m1 = '0; last.tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({39'd0, out_valid}, 40'd0, "R1", "out_valid");
        chk(fac_o, 40'd0, "R1", "factors");
        chk({24'd0, mask0_o, mask1_o}, 40'd0, "R1", "masks");
        started = 1'b1;

        // R2 immediate mode, distinct positive and signed extremes
        send(2'd1, 9'h0a5, 9'h03c, 32'h0, "R2");
        idle(2);
        send(2'd1, 9'h1ff, 9'h100, 32'h0, "R2");
        idle(1);
        send(2'd1, 9'h0ff, 9'h001, 32'h0, "R2");
        idle(2);
        // R4 / R5 shift mode patterns
        send(2'd2, 9'h0, 9'h0, 32'h0000_000a, "R4");
        idle(1);
        send(2'd2, 9'h0, 9'h0, 32'h0000_000f, "R5");
        idle(1);
        send(2'd2, 9'h0, 9'h0, 32'h0000_0005, "R4");
        idle(1);
        // R6 upper source bits ignored
        send(2'd2, 9'h1ff, 9'h1ff, 32'hffff_fff0, "R6");
        idle(2);
        // R7 unused mode codes
        send(2'd1, 9'h077, 9'h133, 32'h0, "R2");
        send(2'd0, 9'h077, 9'h133, 32'hf, "R7");
        send(2'd3, 9'h1aa, 9'h155, 32'hf, "R7");
        // R8 back-to-back stream then drain
        send(2'd2, 9'h0, 9'h0, 32'h0000_0003, "R8");
        send(2'd1, 9'h180, 9'h07f, 32'h0, "R8");
        idle(4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule